// File: doc/BRIEF.md
# Interrupt Controller Command and Acknowledge Unit

This block is the programming and servicing front end of one eight-line interrupt controller. Software reaches it through a byte-wide port with a single address bit. Writes on address 0 either start an initialization sequence, issue a status command (arm a poll, choose which register a read returns, set the special-mask flag), or issue one of eight end-of-interrupt and rotation commands. Writes on address 1 either carry the later words of an initialization sequence or load the mask register. The unit holds the in-service register, the rotating priority base, the mask, the vector base and the mode flags, and drives them to a separate priority resolver.

The resolver sends back its winning line together with a valid flag. On an acknowledge strobe the unit marks that line in service, or retires it at once when automatic end-of-interrupt is set, and presents the vector number one cycle later. A read taken while a poll is armed returns the winning line number instead of a register. It also retires that line and sends a one-cycle clear pulse for its pending bit back to the trigger stage. Pending bits are captured elsewhere and arrive on an input.

Top module: `irq_cmd_ack_unit`

## Requirements
- R1: After reset the in-service register, mask, rotation base, vector output, read data, clear pulse and the nesting and special-mask flags are all zero. The automatic end-of-interrupt and poll flags are clear, the read select points at pending, and the unit is in normal mode.
- R2: An address-0 write with bit 4 set starts initialization and clears the mask, rotation base, special-mask flag and read select. Bit 0 of that write records whether a mode word follows; when bit 0 is 0, the nesting and automatic end-of-interrupt flags are cleared. The next address-1 write loads the vector base from bits 7:3. The write after it is discarded. If a mode word was requested, the next address-1 write sets the nesting flag from bit 4 and the automatic end-of-interrupt flag from bit 1. The unit then returns to normal mode.
- R3: An address-0 write with bit 4 clear and bit 3 set is a status command. When its bit 1 is set, the read select is loaded from bit 0. A later non-poll address-0 read returns the in-service register when the select is 1 and the pending input when it is 0.
- R4: In a status command with bit 6 set, the special-mask flag is loaded from bit 5. When bit 6 is clear, the flag is unchanged.
- R5: An address-0 write with bits 4 and 3 clear is a command coded in bits 7:5. Code 0 clears and code 4 sets the rotate-on-automatic-end-of-interrupt flag.
- R6: Code 1 clears the in-service bit of the highest-priority in-service line. Priority is highest at the rotation base and falls with each line number above it, modulo 8. Code 5 does the same and also sets the rotation base to that line plus 1, modulo 8. With nothing in service, both codes have no effect.
- R7: Code 3 clears the in-service bit of the line in bits 2:0. Code 6 sets the rotation base to bits 2:0 plus 1, modulo 8. Code 7 does both. Code 2 changes nothing.
- R8: In normal mode an address-1 write loads the mask, and a non-poll address-1 read returns it.
- R9: On acknowledge with a valid winner and automatic end-of-interrupt clear, the winner's in-service bit is set. The vector output becomes the vector base in bits 7:3 and the line in bits 2:0. With no valid winner, the vector carries line 7 and the in-service register is unchanged.
- R10: On acknowledge with automatic end-of-interrupt set, the winner's in-service bit ends clear. The rotation base becomes the line plus 1 if the rotate flag is set, and is unchanged otherwise.
- R11: Status bit 2 arms a poll. The next read, at either address, returns the winning line in bits 2:0 with zeros above. It also clears that line's in-service bit, drives a one-hot pulse on the clear output for one cycle, and disarms the poll. With no winner the read returns 7 and nothing is cleared.
- R12: Register state changes only at the clock edge that samples a strobe, and read data appears in the cycle after the read strobe. At most one of the write, read and acknowledge strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 1 | Register address bit |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| ack | input | 1 | Interrupt acknowledge strobe |
| irr | input | 8 | Pending lines from the trigger stage |
| win_valid | input | 1 | Resolver has a winning line |
| win_line | input | 3 | Resolver's winning line |
| rd_data | output | 8 | Registered read byte |
| vec_out | output | 8 | Vector number of the last acknowledge |
| pend_clr | output | 8 | One-cycle pending-clear pulse after a poll read |
| isr_o | output | 8 | In-service register |
| imr_o | output | 8 | Mask register |
| rot_base_o | output | 3 | Line that currently has top priority |
| nest_o | output | 1 | Special nesting mode flag |
| smask_o | output | 1 | Special-mask flag |

## Verification
The assertions check the following on every cycle: the in-service bit set or retired by each acknowledge, the vector assembled from base and line, the clearing done by initialization, poll disarming, the one-hot clear pulse, and that the in-service register holds still when no strobe is present. Other behaviour depends on sequences of writes, so only the bench scenarios can show it. This covers the walk through the initialization words with and without a mode word, the discarded word, priority search from a rotated base for non-specific end-of-interrupt, the choice of register returned by a read, and a poll with no winner.

// File: rtl/irq_cau_pkg.sv
package irq_cau_pkg;
  localparam int LINES = 8;
  localparam int LW    = $clog2(LINES);
  localparam int DW    = LINES;
  localparam int BW    = DW - LW;

  typedef enum logic [1:0] {ST_NORMAL, ST_BASE, ST_SKIP, ST_MODE} init_st_t;

  typedef enum logic [2:0] {
    OP_ROT_OFF  = 3'd0,
    OP_EOI      = 3'd1,
    OP_NOP      = 3'd2,
    OP_SPEC     = 3'd3,
    OP_ROT_ON   = 3'd4,
    OP_EOI_ROT  = 3'd5,
    OP_SETPRI   = 3'd6,
    OP_SPEC_ROT = 3'd7
  } cmd_op_t;

  // Highest-priority set bit, searching upward from base; {found, line}
  function automatic logic [LW:0] top_line(input logic [LINES-1:0] v,
                                           input logic [LW-1:0] base);
    logic [LW:0] r;
    r = '0;
    for (int k = LINES - 1; k >= 0; k--) begin
      logic [LW-1:0] ln;
      ln = base + LW'(k);
      if (v[ln]) r = {1'b1, ln};
    end
    return r;
  endfunction

  function automatic logic [LW-1:0] next_line(input logic [LW-1:0] l);
    return l + 1'b1;
  endfunction
endpackage

// File: rtl/irq_cau_init.sv
module irq_cau_init
  import irq_cau_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_wr,
  input  logic          data_wr,
  input  logic [DW-1:0] wr_data,
  output logic [BW-1:0] vec_base,
  output logic [DW-1:0] imr,
  output logic          nest,
  output logic          aeoi
);
  init_st_t st;
  logic     need_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_NORMAL;
      need_mode <= 1'b0;
      vec_base  <= '0;
      imr       <= '0;
      nest      <= 1'b0;
      aeoi      <= 1'b0;
    end else if (init_wr) begin
      need_mode <= wr_data[0];
      imr       <= '0;
      st        <= ST_BASE;
      if (!wr_data[0]) begin
        nest <= 1'b0;
        aeoi <= 1'b0;
      end
    end else if (data_wr) begin
      case (st)
        ST_NORMAL: imr <= wr_data;
        ST_BASE: begin
          vec_base <= wr_data[DW-1:LW];
          st       <= ST_SKIP;
        end
        ST_SKIP: st <= need_mode ? ST_MODE : ST_NORMAL;
        ST_MODE: begin
          nest <= wr_data[4];
          aeoi <= wr_data[1];
          st   <= ST_NORMAL;
        end
        default: st <= ST_NORMAL;
      endcase
    end
  end
endmodule

// File: rtl/irq_cau_svc.sv
module irq_cau_svc
  import irq_cau_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_wr,
  input  logic             cmd_wr,
  input  logic [2:0]       cmd_code,
  input  logic [LW-1:0]    cmd_line,
  input  logic             ack,
  input  logic             win_valid,
  input  logic [LW-1:0]    win_line,
  input  logic             aeoi,
  input  logic [BW-1:0]    vec_base,
  input  logic             poll_take,
  output logic [LINES-1:0] isr,
  output logic [LW-1:0]    rot_base,
  output logic [DW-1:0]    vec_out
);
  cmd_op_t     op;
  logic [LW:0] hi;
  logic        rot_aeoi;

  assign op = cmd_op_t'(cmd_code);
  assign hi = top_line(isr, rot_base);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr      <= '0;
      rot_base <= '0;
      rot_aeoi <= 1'b0;
      vec_out  <= '0;
    end else if (init_wr) begin
      rot_base <= '0;
    end else if (cmd_wr) begin
      case (op)
        OP_ROT_OFF: rot_aeoi <= 1'b0;
        OP_ROT_ON:  rot_aeoi <= 1'b1;
        OP_EOI, OP_EOI_ROT: begin
          if (hi[LW]) begin
            isr[hi[LW-1:0]] <= 1'b0;
            if (op == OP_EOI_ROT) rot_base <= next_line(hi[LW-1:0]);
          end
        end
        OP_SPEC:    isr[cmd_line] <= 1'b0;
        OP_SETPRI:  rot_base <= next_line(cmd_line);
        OP_SPEC_ROT: begin
          isr[cmd_line] <= 1'b0;
          rot_base      <= next_line(cmd_line);
        end
        default: ;
      endcase
    end else if (ack) begin
      vec_out <= {vec_base, (win_valid ? win_line : {LW{1'b1}})};
      if (win_valid) begin
        if (aeoi) begin
          isr[win_line] <= 1'b0;
          if (rot_aeoi) rot_base <= next_line(win_line);
        end else begin
          isr[win_line] <= 1'b1;
        end
      end
    end else if (poll_take) begin
      isr[win_line] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_cau_rdport.sv
module irq_cau_rdport
  import irq_cau_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_wr,
  input  logic             stat_wr,
  input  logic             poll_req,
  input  logic             sel_ld,
  input  logic             sel_val,
  input  logic             sm_ld,
  input  logic             sm_val,
  input  logic             rd_en,
  input  logic             addr,
  input  logic [LINES-1:0] irr,
  input  logic [LINES-1:0] isr,
  input  logic [DW-1:0]    imr,
  input  logic             win_valid,
  input  logic [LW-1:0]    win_line,
  output logic             poll_armed,
  output logic             poll_take,
  output logic             smask,
  output logic [DW-1:0]    rd_data,
  output logic [LINES-1:0] pend_clr
);
  logic read_sel;

  assign poll_take = rd_en && poll_armed && win_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      poll_armed <= 1'b0;
      read_sel   <= 1'b0;
      smask      <= 1'b0;
      rd_data    <= '0;
      pend_clr   <= '0;
    end else begin
      pend_clr <= '0;
      if (init_wr) begin
        read_sel <= 1'b0;
        smask    <= 1'b0;
      end else if (stat_wr) begin
        if (poll_req) poll_armed <= 1'b1;
        if (sel_ld)   read_sel   <= sel_val;
        if (sm_ld)    smask      <= sm_val;
      end
      if (rd_en) begin
        if (poll_armed) begin
          poll_armed <= 1'b0;
          rd_data    <= {{(DW-LW){1'b0}}, (win_valid ? win_line : {LW{1'b1}})};
          if (win_valid) pend_clr <= LINES'(1) << win_line;
        end else if (addr) begin
          rd_data <= imr;
        end else begin
          rd_data <= read_sel ? isr : irr;
        end
      end
    end
  end
endmodule

// File: rtl/irq_cmd_ack_unit.sv
module irq_cmd_ack_unit
  import irq_cau_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic             ack,
  input  logic [LINES-1:0] irr,
  input  logic             win_valid,
  input  logic [LW-1:0]    win_line,
  output logic [DW-1:0]    rd_data,
  output logic [DW-1:0]    vec_out,
  output logic [LINES-1:0] pend_clr,
  output logic [LINES-1:0] isr_o,
  output logic [DW-1:0]    imr_o,
  output logic [LW-1:0]    rot_base_o,
  output logic             nest_o,
  output logic             smask_o
);
  // Decoded write events, named for the checker
  logic          init_wr, stat_wr, cmd_wr, data_wr;
  logic          aeoi_en, poll_armed, poll_take;
  logic [BW-1:0] vec_base;

  assign init_wr = wr_en && !addr &&  wr_data[4];
  assign stat_wr = wr_en && !addr && !wr_data[4] &&  wr_data[3];
  assign cmd_wr  = wr_en && !addr && !wr_data[4] && !wr_data[3];
  assign data_wr = wr_en &&  addr;

  irq_cau_init u_init (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_wr  (init_wr),
    .data_wr  (data_wr),
    .wr_data  (wr_data),
    .vec_base (vec_base),
    .imr      (imr_o),
    .nest     (nest_o),
    .aeoi     (aeoi_en)
  );

  irq_cau_svc u_svc (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_wr   (init_wr),
    .cmd_wr    (cmd_wr),
    .cmd_code  (wr_data[7:5]),
    .cmd_line  (wr_data[LW-1:0]),
    .ack       (ack),
    .win_valid (win_valid),
    .win_line  (win_line),
    .aeoi      (aeoi_en),
    .vec_base  (vec_base),
    .poll_take (poll_take),
    .isr       (isr_o),
    .rot_base  (rot_base_o),
    .vec_out   (vec_out)
  );

  irq_cau_rdport u_rdp (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_wr    (init_wr),
    .stat_wr    (stat_wr),
    .poll_req   (wr_data[2]),
    .sel_ld     (wr_data[1]),
    .sel_val    (wr_data[0]),
    .sm_ld      (wr_data[6]),
    .sm_val     (wr_data[5]),
    .rd_en      (rd_en),
    .addr       (addr),
    .irr        (irr),
    .isr        (isr_o),
    .imr        (imr_o),
    .win_valid  (win_valid),
    .win_line   (win_line),
    .poll_armed (poll_armed),
    .poll_take  (poll_take),
    .smask      (smask_o),
    .rd_data    (rd_data),
    .pend_clr   (pend_clr)
  );
endmodule

// File: rtl/irq_cau_chk.sv
module irq_cau_chk
  import irq_cau_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic             ack,
  input logic             win_valid,
  input logic [LW-1:0]    win_line,
  input logic             init_wr,
  input logic             aeoi_en,
  input logic             poll_armed,
  input logic [BW-1:0]    vec_base,
  input logic [DW-1:0]    vec_out,
  input logic [LINES-1:0] pend_clr,
  input logic [LINES-1:0] isr_o,
  input logic [DW-1:0]    imr_o,
  input logic [LW-1:0]    rot_base_o,
  input logic             smask_o
);
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    init_wr |=> (imr_o == '0) && (rot_base_o == '0) && !smask_o); // R2

  AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && win_valid && !aeoi_en) |=> isr_o[$past(win_line)]); // R9

  AST_ACK_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> vec_out == {$past(vec_base),
                        ($past(win_valid) ? $past(win_line) : {LW{1'b1}})}); // R9

  AST_AUTO_EOI_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && win_valid && aeoi_en) |=> !isr_o[$past(win_line)]); // R10

  AST_POLL_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && poll_armed) |=> !poll_armed); // R11

  AST_CLEAR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend_clr)); // R11

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, rd_en, ack})); // R12

  AST_ISR_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en || rd_en || ack) |=> $stable(isr_o)); // R12
endmodule

bind irq_cmd_ack_unit irq_cau_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .ack        (ack),
  .win_valid  (win_valid),
  .win_line   (win_line),
  .init_wr    (init_wr),
  .aeoi_en    (aeoi_en),
  .poll_armed (poll_armed),
  .vec_base   (vec_base),
  .vec_out    (vec_out),
  .pend_clr   (pend_clr),
  .isr_o      (isr_o),
  .imr_o      (imr_o),
  .rot_base_o (rot_base_o),
  .smask_o    (smask_o)
);

// File: tb/irq_cmd_ack_unit_tb.sv
`timescale 1ns/1ps
module irq_cmd_ack_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0, ack = 1'b0;
  logic [7:0] wr_data = '0, irr = '0;
  logic       win_valid = 1'b0;
  logic [2:0] win_line = '0;
  logic [7:0] rd_data, vec_out, pend_clr, isr_o, imr_o;
  logic [2:0] rot_base_o;
  logic       nest_o, smask_o;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_cmd_ack_unit u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .ack(ack), .irr(irr), .win_valid(win_valid), .win_line(win_line),
    .rd_data(rd_data), .vec_out(vec_out), .pend_clr(pend_clr), .isr_o(isr_o),
    .imr_o(imr_o), .rot_base_o(rot_base_o), .nest_o(nest_o), .smask_o(smask_o)
  );

  // Bench model of the programmed state
  logic [7:0] m_isr = '0, m_imr = '0;
  logic [4:0] m_base = '0;
  logic [2:0] m_rot = '0;
  bit m_nest, m_aeoi, m_raeoi, m_smask, m_rsel, m_poll, m_need;
  int m_phase = 0; // 0 normal, 1 base, 2 discard, 3 mode word

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    chk({tag, " isr"}, isr_o, m_isr);
    chk({tag, " mask"}, imr_o, m_imr);
    chk({tag, " rot"}, {5'd0, rot_base_o}, {5'd0, m_rot});
    chk({tag, " flags"}, {6'd0, nest_o, smask_o}, {6'd0, m_nest, m_smask});
  endtask

  // Priority search written as a distance scan from the base
  task automatic m_retire_top(input bit rotate);
    bit found = 0;
    for (int d = 0; d < 8; d++) begin
      int ln;
      ln = (int'(m_rot) + d) % 8;
      if (!found && m_isr[ln]) begin
        found = 1;
        m_isr[ln] = 1'b0;
        if (rotate) m_rot = 3'((ln + 1) % 8);
      end
    end
  endtask

  task automatic m_write(input bit a, input logic [7:0] d);
    if (a) begin
      case (m_phase)
        0: m_imr = d;
        1: begin m_base = d[7:3]; m_phase = 2; end
        2: m_phase = m_need ? 3 : 0;
        default: begin m_nest = d[4]; m_aeoi = d[1]; m_phase = 0; end
      endcase
    end else if (d[4]) begin
      m_need = d[0]; m_imr = '0; m_rot = '0; m_smask = 0; m_rsel = 0; m_phase = 1;
      if (!d[0]) begin m_nest = 0; m_aeoi = 0; end
    end else if (d[3]) begin
      if (d[2]) m_poll = 1;
      if (d[1]) m_rsel = d[0];
      if (d[6]) m_smask = d[5];
    end else begin
      case (d[7:5])
        3'd0: m_raeoi = 0;
        3'd4: m_raeoi = 1;
        3'd1: m_retire_top(0);
        3'd5: m_retire_top(1);
        3'd3: m_isr[d[2:0]] = 1'b0;
        3'd6: m_rot = d[2:0] + 3'd1;
        3'd7: begin m_isr[d[2:0]] = 1'b0; m_rot = d[2:0] + 3'd1; end
        default: ;
      endcase
    end
  endtask

  task automatic do_wr(input bit a, input logic [7:0] d, input string tag);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    m_write(a, d);
    chk_state(tag);
  endtask

  task automatic do_ack(input bit v, input logic [2:0] l, input string tag);
    @(negedge clk); win_valid = v; win_line = l; ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    chk({tag, " vector"}, vec_out, {m_base, (v ? l : 3'd7)});
    if (v) begin
      if (m_aeoi) begin
        m_isr[l] = 1'b0;
        if (m_raeoi) m_rot = l + 3'd1;
      end else m_isr[l] = 1'b1;
    end
    chk_state(tag);
  endtask

  task automatic do_rd(input bit a, input bit v, input logic [2:0] l, input string tag);
    logic [7:0] e_rd, e_clr;
    @(negedge clk); addr = a; win_valid = v; win_line = l; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    e_clr = '0;
    if (m_poll) begin
      m_poll = 0;
      e_rd = v ? {5'd0, l} : 8'd7;
      if (v) begin m_isr[l] = 1'b0; e_clr = 8'd1 << l; end
    end else e_rd = a ? m_imr : (m_rsel ? m_isr : irr);
    chk({tag, " data"}, rd_data, e_rd);
    chk({tag, " clear"}, pend_clr, e_clr);
    chk_state(tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_state("R1 reset");
    chk("R1 vector", vec_out, 8'h00);
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 clear", pend_clr, 8'h00);

    // R2 four-word initialization
    do_wr(0, 8'h11, "R2 init");
    do_wr(1, 8'h47, "R2 base");
    do_wr(1, 8'hFF, "R2 discarded");
    do_wr(1, 8'h10, "R2 mode");
    chk("R2 nest set", {7'd0, nest_o}, 8'd1);

    // R8 mask load and readback
    do_wr(1, 8'hA5, "R8 mask");
    do_rd(1, 0, 3'd0, "R8 readback");

    // R9 acknowledges
    do_ack(1, 3'd3, "R9 ack3");
    chk("R9 vec value", vec_out, 8'h43);
    do_ack(1, 3'd5, "R9 ack5");
    do_ack(0, 3'd2, "R9 spurious");
    chk("R9 spurious vec", vec_out, 8'h47);

    // R6 / R7 end-of-interrupt and rotation
    do_wr(0, 8'h20, "R6 eoi");
    chk("R6 isr after eoi", isr_o, 8'h20);
    do_wr(0, 8'hC4, "R7 setpri");
    chk("R7 rot", {5'd0, rot_base_o}, 8'd5);
    do_ack(1, 3'd1, "R9 ack1");
    do_wr(0, 8'hA0, "R6 eoi rot");
    chk("R6 rotated", {5'd0, rot_base_o}, 8'd6);
    do_wr(0, 8'h61, "R7 specific");
    do_wr(0, 8'h40, "R7 nop");
    do_wr(0, 8'hE2, "R7 spec rot");
    do_wr(0, 8'h20, "R6 empty eoi");

    // R3 register select, R12 read timing
    irr = 8'h9C;
    do_ack(1, 3'd6, "R9 ack6");
    do_wr(0, 8'h0B, "R3 select isr");
    do_rd(0, 0, 3'd0, "R3 read isr");
    do_wr(0, 8'h0A, "R3 select irr");
    @(negedge clk); addr = 0; rd_en = 1'b1;
    #1 chk("R12 not yet updated", rd_data, m_isr);
    @(negedge clk); rd_en = 1'b0;
    chk("R12 R3 read irr", rd_data, irr);
    do_wr(0, 8'h09, "R3 no load");
    do_rd(0, 0, 3'd0, "R3 select held");

    // R4 special mask
    do_wr(0, 8'h68, "R4 smask on");
    do_wr(0, 8'h28, "R4 no load");
    do_wr(0, 8'h48, "R4 smask off");

    // R11 poll
    do_wr(0, 8'h0C, "R11 arm");
    do_rd(1, 1, 3'd6, "R11 poll hit");
    do_rd(1, 1, 3'd6, "R11 disarmed");
    do_wr(0, 8'h0C, "R11 arm2");
    do_rd(0, 0, 3'd4, "R11 poll empty");

    // R2 three-word initialization clears modes, discarded word keeps mask
    do_wr(0, 8'h10, "R2 init3");
    do_wr(1, 8'h8D, "R2 base3");
    do_wr(1, 8'h33, "R2 discarded3");
    do_wr(1, 8'h5A, "R2 back to normal");

    // R10 / R5 automatic end-of-interrupt
    do_wr(0, 8'h11, "R10 init");
    do_wr(1, 8'h20, "R10 base");
    do_wr(1, 8'h00, "R10 discarded");
    do_wr(1, 8'h02, "R10 mode");
    do_wr(0, 8'h80, "R5 rot on");
    do_ack(1, 3'd4, "R10 ack rotate");
    chk("R10 rot", {5'd0, rot_base_o}, 8'd5);
    do_wr(0, 8'h00, "R5 rot off");
    do_ack(1, 3'd2, "R10 ack no rotate");

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      int sel;
      logic [7:0] d;
      sel = int'($urandom_range(0, 9));
      d = 8'($urandom);
      if (sel < 3) do_ack($urandom_range(0, 3) != 0, d[2:0], "R9 rand ack");
      else if (sel < 5) do_wr(0, {d[7:5], 1'b0, d[3:0]}, "R6 rand cmd");
      else if (sel == 5) do_wr(0, d, "R2 rand addr0");
      else if (sel == 6) do_wr(1, d, "R8 rand addr1");
      else begin
        irr = 8'($urandom);
        do_rd(d[7], d[6] | d[5], d[2:0], "R11 rand read");
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule